// File: doc/BRIEF.md
# RAM Pattern Self-Test Engine

This block is a built-in self-test sequencer for a synchronous single-port RAM with a one-cycle read latency. It walks a 1 KiB region, split into four pages of 256 bytes, through four data patterns. Each pattern gets a fill pass that writes every location and then a verify pass that reads every location back and compares it. The patterns are all zeros, all ones, every byte holding its own index within the page, and every byte holding its page number. The last two patterns catch address decoding faults, where two addresses land on the same cell. Stuck data bits alone would not reveal those.

Within a pass the engine visits one index in all four pages before it moves to the next index. An 8-bit status byte shows the current pass number and reads $08 once the whole sequence has succeeded. The first mismatch stops the test. The status byte then rotates through three values: the pass that failed, the failing page placed in the upper nibble, and the failing index. Each value is held for a programmable number of cycles, slow enough for a person or a logic probe to read. A start pulse reruns everything from the beginning at any time.

Top module: `ram_bist`

## Requirements
- R1: The RAM address is `{page, index}`, with the page in mem_addr[9:8] (0..3) and the index in mem_addr[7:0] (0..255), so the test covers 1024 bytes.
- R2: The passes run in a fixed order, with pass number n = 0..7. Even passes write, with mem_we high on every cycle of the pass. Odd passes read. The pattern for passes 2k and 2k+1 is $00 for k=0, $FF for k=1, the index for k=2 and the page number for k=3.
- R3: While the test runs, status equals the pass number. Passes 0 to 6 each last exactly 1024 cycles. Pass 7 shows for 1025 cycles, which includes the cycle that compares its final read. The pass number rises by exactly one at each boundary.
- R4: Within a pass, consecutive cycles address page 0, 1, 2 and 3 at one index, and then the index advances. The index wraps from 255 to 0 at the end of the pass.
- R5: A verify pass compares mem_rdata with the expected pattern in the cycle after it issues the address.
- R6: On the first mismatch the engine stops. It never writes again, and done=1 with pass=0.
- R7: After a failure, status repeats the sequence: failing pass number, then page×16 ($00/$10/$20/$30), then failing index. Each value is held for DWELL cycles.
- R8: After all eight passes succeed, status holds $08 with done=1 and pass=1 until the next start.
- R9: Reset leaves the engine idle, with status $00, done=0 and no writes, until start is seen. A start in any state restarts at pass 0, index 0, page 0 and clears any recorded failure.
- R10: A mismatch on the last read of a verify pass is still caught. It is reported with that verify pass number, even though the next pass has already begun writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous pulse that starts or restarts the test |
| mem_addr | output | 10 | RAM address {page, index} |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the address |
| status | output | 8 | Pass number, $08 on success, or rotating failure report |
| done | output | 1 | Test finished, either success or failure |
| pass | output | 1 | Test finished with no mismatch |

## Verification
When a start is sampled at a clock edge, pass 0 and its first write appear right after that edge. Pass p then begins 1024·p edges later, and $08 appears at edge 8193. The bench counts cycles from the start pulse and samples at the negative edge, so every check lands on the cycle where the result is due. A read mismatch becomes visible one edge after the read data returns, as done rising with the failing pass on status. Each later field of the failure report is sampled exactly DWELL edges after the previous one. The injected faults are a stuck bit, an aliased index bit, an aliased page bit and a stuck bit on the very last location of a verify pass. The bench predicts each fault's pass, page and index from the pattern arithmetic.

// File: rtl/ram_bist.sv
module ram_bist #(
  parameter int DW    = 8,
  parameter int IW    = 8,
  parameter int PW    = 2,
  parameter int DWELL = 1 << 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [PW+IW-1:0]   mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               mem_we,
  input  logic [DW-1:0]      mem_rdata,
  output logic [7:0]         status,
  output logic               done,
  output logic               pass
);
  localparam int CW = $clog2(DWELL + 1);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FIN, S_DONE, S_FAIL} st_t;
  st_t st;

  logic [3:0]    phase;
  logic [PW-1:0] pg;
  logic [IW-1:0] idx;
  logic [DW-1:0] pat;

  logic          chk_vld;
  logic [DW-1:0] chk_exp;
  logic [PW-1:0] chk_pg;
  logic [IW-1:0] chk_idx;
  logic [3:0]    chk_ph;

  logic [3:0]    f_ph;
  logic [PW-1:0] f_pg;
  logic [IW-1:0] f_idx;
  logic [CW-1:0] presc;
  logic [1:0]    sel;

  wire verify   = phase[0];
  wire last_loc = (&pg) && (&idx);
  wire err      = (st == S_RUN || st == S_FIN) && chk_vld && (mem_rdata != chk_exp);

  always_comb begin
    case (phase[2:1])
      2'd0:    pat = '0;
      2'd1:    pat = '1;
      2'd2:    pat = DW'(idx);
      default: pat = DW'(pg);
    endcase
  end

  assign mem_addr  = {pg, idx};
  assign mem_wdata = pat;
  assign mem_we    = (st == S_RUN) && !verify;
  assign done      = (st == S_DONE) || (st == S_FAIL);
  assign pass      = (st == S_DONE);

  always_comb begin
    case (st)
      S_IDLE: status = 8'h00;
      S_FAIL: case (sel)
                2'd0:    status = 8'(f_ph);
                2'd1:    status = 8'(f_pg) << 4;
                default: status = 8'(f_idx);
              endcase
      default: status = 8'(phase);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      st      <= rst ? S_IDLE : S_RUN;
      phase   <= '0;
      pg      <= '0;
      idx     <= '0;
      chk_vld <= 1'b0;
      chk_exp <= '0;
      chk_pg  <= '0;
      chk_idx <= '0;
      chk_ph  <= '0;
      f_ph    <= '0;
      f_pg    <= '0;
      f_idx   <= '0;
      presc   <= '0;
      sel     <= '0;
    end else if (err) begin
      st      <= S_FAIL;
      f_ph    <= chk_ph;
      f_pg    <= chk_pg;
      f_idx   <= chk_idx;
      chk_vld <= 1'b0;
      presc   <= '0;
      sel     <= '0;
    end else begin
      case (st)
        S_RUN: begin
          chk_vld     <= verify;
          chk_exp     <= pat;
          chk_pg      <= pg;
          chk_idx     <= idx;
          chk_ph      <= phase;
          {idx, pg}   <= {idx, pg} + 1'b1;
          if (last_loc) begin
            if (phase == 4'd7) st <= S_FIN;
            else               phase <= phase + 4'd1;
          end
        end
        S_FIN: begin
          chk_vld <= 1'b0;
          phase   <= 4'd8;
          st      <= S_DONE;
        end
        S_FAIL: begin
          if (presc == CW'(DWELL - 1)) begin
            presc <= '0;
            sel   <= (sel == 2'd2) ? 2'd0 : sel + 2'd1;
          end else begin
            presc <= presc + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_addr_order_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && $past(st) == S_RUN && !$past(start) && !$past(err))
      |-> (pg == $past(pg) + 1'b1) && (idx == $past(idx) + IW'($past(&pg))));

  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && $past(st) == S_RUN && !$past(start) && phase != $past(phase))
      |-> (phase == $past(phase) + 4'd1) && pg == '0 && idx == '0);

  p_fail_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_FAIL && !start) |=> (st == S_FAIL && !mem_we && done && !pass));

  p_dwell_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_FAIL && !start && presc != CW'(DWELL - 1)) |=> $stable(status));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pass && !start) |=> (pass && status == 8'h08 && !mem_we));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> (st == S_RUN && status == 8'h00 && mem_addr == '0 && !done));
endmodule

// File: tb/ram_bist_tb_top.sv
module ram_bist_tb_top;
  localparam int DWELL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, status;
  logic mem_we, done, pass;

  int checks = 0, errors = 0;
  int fault = 0;
  bit mon_en = 1'b0;
  int wr_n = 0, wr_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ram_bist #(.DW(8), .IW(8), .PW(2), .DWELL(DWELL)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .status(status), .done(done), .pass(pass));

  logic [7:0] mem [0:1023];

  function automatic int eff(input int a);
    if (fault == 2) return a & ~32'h080;
    if (fault == 4) return a & ~32'h200;
    return a;
  endfunction

  always_ff @(posedge clk) begin
    logic [7:0] d;
    if (mem_we) mem[eff(int'(mem_addr))] <= mem_wdata;
    d = mem[eff(int'(mem_addr))];
    if (fault == 1 && mem_addr == 10'h245) d = d | 8'h08;
    if (fault == 3 && mem_addr == 10'h3FF) d = d & 8'h7F;
    mem_rdata <= d;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 200000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_en && mem_we) begin
      int k, j, ep, ei, ed;
      k = wr_n / 1024; j = wr_n % 1024; ep = j % 4; ei = j / 4;
      case (k)
        0: ed = 0;
        1: ed = 255;
        2: ed = ei;
        default: ed = ep;
      endcase
      if (int'(mem_addr) != ep * 256 + ei || int'(mem_wdata) != ed) wr_bad = wr_bad + 1;
      wr_n = wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(status == 8'h00 && !done && !pass, "R9 restart status", status, 0);
    chk(mem_addr == 10'h000, "R9 restart address", mem_addr, 0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic fail_case(input int mode, input int eph, input int epg, input int eidx,
                           input string tag);
    fault = mode;
    pulse_start();
    wait_done();
    chk(done && !pass, {tag, " R6 fail flags"}, {done, pass}, 2);
    chk(int'(status) == eph, {tag, " R7 phase field"}, status, eph);
    repeat (DWELL) @(posedge clk);
    @(negedge clk);
    chk(int'(status) == epg * 16, {tag, " R7 page field"}, status, epg * 16);
    repeat (DWELL) @(posedge clk);
    @(negedge clk);
    chk(int'(status) == eidx, {tag, " R7 index field"}, status, eidx);
    repeat (DWELL) @(posedge clk);
    @(negedge clk);
    chk(int'(status) == eph, {tag, " R7 rotation wraps"}, status, eph);
    begin
      int wcount = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (mem_we) wcount++;
      end
      chk(wcount == 0 && done && !pass, {tag, " R6 no writes after fail"}, wcount, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(status == 8'h00 && !done && !pass && !mem_we, "R9 reset state", status, 0);
    repeat (20) @(negedge clk);
    chk(status == 8'h00 && !mem_we && !done, "R9 idle without start", {status, mem_we}, 0);

    pulse_start();
    repeat (3500) @(negedge clk);
    chk(status == 8'h03, "R3 mid-run pass number", status, 3);

    wr_n = 0; wr_bad = 0; mon_en = 1'b1;
    pulse_start();
    begin
      int t [0:8];
      int c = 0;
      int last = 0;
      for (int p = 0; p <= 8; p++) t[p] = -1;
      t[0] = 0;
      while (c < 9000 && !done) begin
        @(negedge clk);
        c++;
        if (int'(status) != last) begin
          if (int'(status) <= 8) t[status] = c;
          chk(int'(status) == last + 1, "R3 pass steps by one", status, last + 1);
          last = int'(status);
        end
      end
      mon_en = 1'b0;
      for (int p = 1; p <= 7; p++)
        chk(t[p] == 1024 * p, "R3 pass start cycle", t[p], 1024 * p);
      chk(t[8] == 8193, "R3 R5 success after final compare", t[8], 8193);
    end
    chk(wr_n == 4096, "R2 write count", wr_n, 4096);
    chk(wr_bad == 0, "R1 R2 R4 write order and patterns", wr_bad, 0);
    chk(done && pass && status == 8'h08, "R8 success flags", status, 8);
    repeat (100) @(negedge clk);
    chk(done && pass && status == 8'h08 && !mem_we, "R8 success holds", status, 8);

    fail_case(1, 1, 2, 8'h45, "stuck bit");
    fail_case(2, 5, 0, 0, "index alias R5");
    fail_case(4, 7, 0, 0, "page alias R5");
    fail_case(3, 3, 3, 8'hFF, "last read R10");

    fault = 0;
    pulse_start();
    wait_done();
    chk(done && pass && status == 8'h08, "R9 rerun after fail clears error", status, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule